// File: doc/BRIEF.md
# Single-Channel DMA Transfer Engine

This block is one DMA channel that copies a programmed number of units from a source address to a destination address over a single-beat bus master port. Software programs it through a small register write port. One word holds the channel setup and the trigger. Three further words hold the source base, the destination base and the unit count. A fifth address clears the status flags. The channel can copy from memory to memory, from a peripheral to memory, or from memory to a peripheral. In the two peripheral directions, each unit waits for a handshake input from the peripheral.

Each unit is moved as one read beat followed by one write beat. Either address can step forward by the active unit size after every unit, or stay fixed. A completed transfer clears the trigger bit and sets a sticky done flag. A bus error stops the channel and sets a sticky error flag, and the channel then stays halted until software issues a soft reset. A soft reset restarts the engine and its working pointers but keeps the programmed setup. The interrupt line reflects the two flags.

Top module: `dma_chan_engine`

## Requirements
- R1: While the enable bit (control bit 0) is 0, `m_req` is low in the same cycle. An active transfer returns to idle, and `periph_req` and a set trigger start nothing. Once enable is set again, a pending trigger starts the transfer.
- R2: Writing a control word with bit 1 set starts a soft reset. Such a write changes no field other than enable and trigger. The soft reset sends the engine to idle from any state, including the halted state. The next trigger copies again from the programmed source base, destination base and count.
- R3: The soft-reset indication (`ctrl_o[1]`) stays high for SRST_CYCLES cycles and then clears by itself. While it is high, enable and trigger read 0 and control writes are ignored.
- R4: The mode field (control bits 3:2) selects 00 memory-to-memory, 01 peripheral-to-memory or 10 memory-to-peripheral. Memory-to-memory units are always 32 bits wide, step by 4, and never wait for `periph_req`.
- R5: The source direction field (bits 5:4) and the destination direction field (bits 7:6) each select 00 to step the address by the unit size after every unit, or 10 to keep it fixed.
- R6: In the peripheral modes, the width field (bits 9:8) selects 00 for 32 bits (step 4), 01 for 8 bits (step 1) or 10 for 16 bits (step 2). The written data is the read data with the bits above the width cleared.
- R7: Every unit is one read beat at the source address followed by one write beat at the destination address. After `count` units, the trigger bit (control bit 10) clears and `done_o` is set. A count of 0 completes at once with no bus beat.
- R8: In the peripheral modes, no read beat starts until `periph_req` is high.
- R9: A beat accepted with `m_err` high ends all requests from the next cycle onward, clears the trigger bit and sets `err_o`. Any later trigger is ignored until a soft reset.
- R10: A write to the status address (4) with bit 0 set clears `done_o`, and with bit 1 set clears `err_o`. `irq` is high while either flag is set. A flag set in the same cycle as its clear remains set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select: 0 control, 1 source, 2 destination, 3 count, 4 status clear |
| reg_wdata | input | 32 | Register write data |
| periph_req | input | 1 | Peripheral ready-for-unit request |
| m_req | output | 1 | Bus beat request |
| m_we | output | 1 | Beat is a write |
| m_addr | output | ADDR_W | Beat byte address |
| m_wdata | output | 32 | Write beat data |
| m_rdata | input | 32 | Read beat data |
| m_ready | input | 1 | Beat accepted this cycle |
| m_err | input | 1 | Accepted beat ended in error |
| ctrl_o | output | 11 | Control word image, bit 1 showing soft reset in progress |
| done_o | output | 1 | Sticky completion flag |
| err_o | output | 1 | Sticky bus-error flag |
| irq | output | 1 | Interrupt, high while either flag is set |

## Verification
Two events can land on the same clock edge: the completion of the last unit, which sets the done flag, and a software write to the status address that clears it. The bench waits until the final write beat is visible on the bus with `m_ready` high. In that same cycle it drives the status-clear write. After the edge, `done_o` and `irq` must both be 1. The same edge also clears the trigger bit, and the bench checks that too.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

    typedef enum logic [1:0] {
        MODE_M2M = 2'b00,
        MODE_P2M = 2'b01,
        MODE_M2P = 2'b10,
        MODE_RSV = 2'b11
    } xfer_mode_e;

    typedef enum logic [1:0] {
        DIR_INC  = 2'b00,
        DIR_RSV1 = 2'b01,
        DIR_FIX  = 2'b10,
        DIR_RSV3 = 2'b11
    } addr_dir_e;

    typedef enum logic [1:0] {
        WID_32  = 2'b00,
        WID_8   = 2'b01,
        WID_16  = 2'b10,
        WID_RSV = 2'b11
    } unit_width_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_READ,
        ST_WRITE,
        ST_HALT
    } eng_state_e;

    // Control word, MSB first: trig[10] width[9:8] dst[7:6] src[5:4] mode[3:2] srst[1] en[0]
    typedef struct packed {
        logic        trig;
        unit_width_e width;
        addr_dir_e   dst_dir;
        addr_dir_e   src_dir;
        xfer_mode_e  mode;
        logic        srst;
        logic        en;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    localparam logic [2:0] RA_CTRL = 3'd0;
    localparam logic [2:0] RA_SRC  = 3'd1;
    localparam logic [2:0] RA_DST  = 3'd2;
    localparam logic [2:0] RA_CNT  = 3'd3;
    localparam logic [2:0] RA_STAT = 3'd4;

    function automatic logic is_periph(input xfer_mode_e m);
        return (m == MODE_P2M) || (m == MODE_M2P);
    endfunction

    function automatic unit_width_e active_width(input ctrl_t c);
        if (!is_periph(c.mode) || c.width == WID_RSV) return WID_32;
        return c.width;
    endfunction

    function automatic logic [2:0] step_of(input unit_width_e w);
        case (w)
            WID_8:   return 3'd1;
            WID_16:  return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

    function automatic logic [31:0] trim(input unit_width_e w, input logic [31:0] d);
        case (w)
            WID_8:   return {24'd0, d[7:0]};
            WID_16:  return {16'd0, d[15:0]};
            default: return d;
        endcase
    endfunction

endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
    import dma_chan_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int CNT_W       = 16,
    parameter int SRST_CYCLES = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    input  logic              done_evt,
    input  logic              err_evt,
    output ctrl_t             ctrl,
    output logic [ADDR_W-1:0] src_base,
    output logic [ADDR_W-1:0] dst_base,
    output logic [CNT_W-1:0]  cnt_base,
    output logic              srst_busy,
    output logic              done_flag,
    output logic              err_flag
);

    localparam int SC_W = $clog2(SRST_CYCLES + 1);
    localparam logic [SC_W-1:0] SC_LOAD = SC_W'(SRST_CYCLES);

    logic [SC_W-1:0] srst_cnt;
    logic            unused_hi;

    assign unused_hi = &{1'b0, reg_wdata};
    assign srst_busy = (srst_cnt != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl      <= '0;
            src_base  <= '0;
            dst_base  <= '0;
            cnt_base  <= '0;
            srst_cnt  <= '0;
            done_flag <= 1'b0;
            err_flag  <= 1'b0;
        end else begin
            if (srst_busy) srst_cnt <= srst_cnt - 1'b1;

            if (reg_wr && reg_addr == RA_CTRL && !srst_busy) begin
                if (reg_wdata[1]) begin
                    srst_cnt  <= SC_LOAD;
                    ctrl.en   <= 1'b0;
                    ctrl.trig <= 1'b0;
                end else begin
                    ctrl <= ctrl_t'(reg_wdata[CTRL_W-1:0]);
                end
            end
            if (reg_wr && reg_addr == RA_SRC) src_base <= reg_wdata[ADDR_W-1:0];
            if (reg_wr && reg_addr == RA_DST) dst_base <= reg_wdata[ADDR_W-1:0];
            if (reg_wr && reg_addr == RA_CNT) cnt_base <= reg_wdata[CNT_W-1:0];

            // hardware completion or abort wins over a software set
            if (done_evt || err_evt) ctrl.trig <= 1'b0;

            if (reg_wr && reg_addr == RA_STAT) begin
                if (reg_wdata[0]) done_flag <= 1'b0;
                if (reg_wdata[1]) err_flag  <= 1'b0;
            end
            if (done_evt) done_flag <= 1'b1;
            if (err_evt)  err_flag  <= 1'b1;
        end
    end

    AST_SRST_GATES_CTRL: assert property (@(posedge clk) disable iff (rst) srst_busy |-> (!ctrl.en && !ctrl.trig)); // R3
    AST_TRIG_SELF_CLEAR: assert property (@(posedge clk) disable iff (rst) done_evt |=> !ctrl.trig); // R7
    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (rst) (done_evt || err_evt) |=> (done_flag || err_flag)); // R10

endmodule

// File: rtl/dma_chan_fsm.sv
module dma_chan_fsm
    import dma_chan_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  ctrl_t             ctrl,
    input  logic [ADDR_W-1:0] src_base,
    input  logic [ADDR_W-1:0] dst_base,
    input  logic [CNT_W-1:0]  cnt_base,
    input  logic              srst_busy,
    input  logic              periph_req,
    output logic              m_req,
    output logic              m_we,
    output logic [ADDR_W-1:0] m_addr,
    output logic [31:0]       m_wdata,
    input  logic [31:0]       m_rdata,
    input  logic              m_ready,
    input  logic              m_err,
    output logic              done_evt,
    output logic              err_evt
);

    eng_state_e        st;
    logic [ADDR_W-1:0] cur_src, cur_dst, step_ext;
    logic [CNT_W-1:0]  cur_cnt;
    logic [31:0]       hold;
    unit_width_e       wid;
    logic              periph, start, beat_ok, unused_srst;

    assign unused_srst = ctrl.srst;
    assign wid      = active_width(ctrl);
    assign step_ext = {{(ADDR_W-3){1'b0}}, step_of(wid)};
    assign periph   = is_periph(ctrl.mode);

    assign m_req    = (st == ST_READ || st == ST_WRITE) && ctrl.en && !srst_busy;
    assign m_we     = (st == ST_WRITE);
    assign m_addr   = m_we ? cur_dst : cur_src;
    assign m_wdata  = hold;
    assign beat_ok  = m_req && m_ready && !m_err;
    assign err_evt  = m_req && m_ready && m_err;
    assign start    = (st == ST_IDLE) && ctrl.en && ctrl.trig && !srst_busy;
    assign done_evt = (start && cnt_base == '0) ||
                      (st == ST_WRITE && beat_ok && cur_cnt == CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            cur_src <= '0;
            cur_dst <= '0;
            cur_cnt <= '0;
            hold    <= '0;
        end else if (srst_busy) begin
            st      <= ST_IDLE;
            cur_src <= src_base;
            cur_dst <= dst_base;
            cur_cnt <= cnt_base;
            hold    <= '0;
        end else if (!ctrl.en && st != ST_HALT) begin
            st <= ST_IDLE;
        end else begin
            case (st)
                ST_IDLE: if (start) begin
                    cur_src <= src_base;
                    cur_dst <= dst_base;
                    cur_cnt <= cnt_base;
                    if (cnt_base != '0) st <= periph ? ST_WAIT : ST_READ;
                end
                ST_WAIT: if (periph_req) st <= ST_READ;
                ST_READ: begin
                    if (err_evt) st <= ST_HALT;
                    else if (beat_ok) begin
                        hold <= trim(wid, m_rdata);
                        st   <= ST_WRITE;
                    end
                end
                ST_WRITE: begin
                    if (err_evt) st <= ST_HALT;
                    else if (beat_ok) begin
                        if (!ctrl.src_dir[1]) cur_src <= cur_src + step_ext;
                        if (!ctrl.dst_dir[1]) cur_dst <= cur_dst + step_ext;
                        cur_cnt <= cur_cnt - 1'b1;
                        if (cur_cnt == CNT_W'(1)) st <= ST_IDLE;
                        else st <= periph ? ST_WAIT : ST_READ;
                    end
                end
                default: st <= ST_HALT;
            endcase
        end
    end

    AST_READ_THEN_WRITE: assert property (@(posedge clk) disable iff (rst) (beat_ok && !m_we) |=> (st == ST_WRITE)); // R7
    AST_FIXED_SRC_HOLDS: assert property (@(posedge clk) disable iff (rst) (beat_ok && m_we && ctrl.src_dir == DIR_FIX) |=> (cur_src == $past(cur_src))); // R5
    AST_WAIT_FOR_PERIPH: assert property (@(posedge clk) disable iff (rst) (st == ST_WAIT && !periph_req && ctrl.en && !srst_busy) |=> (st == ST_WAIT)); // R8
    AST_HALT_ON_ERROR: assert property (@(posedge clk) disable iff (rst) err_evt |=> !m_req); // R9
    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (rst) (st == ST_HALT && !srst_busy) |=> (st == ST_HALT)); // R9

endmodule

// File: rtl/dma_chan_engine.sv
module dma_chan_engine
    import dma_chan_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int CNT_W       = 16,
    parameter int SRST_CYCLES = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    input  logic              periph_req,
    output logic              m_req,
    output logic              m_we,
    output logic [ADDR_W-1:0] m_addr,
    output logic [31:0]       m_wdata,
    input  logic [31:0]       m_rdata,
    input  logic              m_ready,
    input  logic              m_err,
    output logic [10:0]       ctrl_o,
    output logic              done_o,
    output logic              err_o,
    output logic              irq
);

    ctrl_t             ctrl;
    logic [ADDR_W-1:0] src_base, dst_base;
    logic [CNT_W-1:0]  cnt_base;
    logic              srst_busy, done_evt, err_evt;

    dma_chan_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .SRST_CYCLES(SRST_CYCLES)) u_regs (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .done_evt(done_evt), .err_evt(err_evt), .ctrl(ctrl), .src_base(src_base),
        .dst_base(dst_base), .cnt_base(cnt_base), .srst_busy(srst_busy),
        .done_flag(done_o), .err_flag(err_o)
    );

    dma_chan_fsm #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_fsm (
        .clk(clk), .rst(rst), .ctrl(ctrl), .src_base(src_base), .dst_base(dst_base),
        .cnt_base(cnt_base), .srst_busy(srst_busy), .periph_req(periph_req),
        .m_req(m_req), .m_we(m_we), .m_addr(m_addr), .m_wdata(m_wdata), .m_rdata(m_rdata),
        .m_ready(m_ready), .m_err(m_err), .done_evt(done_evt), .err_evt(err_evt)
    );

    assign ctrl_o = {ctrl[CTRL_W-1:2], srst_busy, ctrl.en};
    assign irq    = done_o || err_o;

    AST_NO_REQ_WHEN_OFF: assert property (@(posedge clk) disable iff (rst) !ctrl_o[0] |-> !m_req); // R1
    AST_IRQ_FOLLOWS_FLAGS: assert property (@(posedge clk) disable iff (rst) (done_o || err_o) |-> irq); // R10

endmodule

// File: tb/dma_chan_engine_bench.sv
module dma_chan_engine_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic        periph_req = 1'b0;
    logic        m_req, m_we, m_ready, m_err;
    logic [31:0] m_addr, m_wdata, m_rdata;
    logic [10:0] ctrl_o;
    logic        done_o, err_o, irq;

    logic        err_on = 1'b0;
    logic [31:0] err_addr = '0;

    int checks = 0;
    int errors = 0;
    int req_cycles = 0;
    bit finished = 0;

    logic [31:0] exp_addr[$];
    logic [31:0] exp_data[$];

    always #10 clk = ~clk;   // 50 MHz

    // memory/peripheral model: data is a function of the address
    assign m_rdata = {~m_addr[15:0], m_addr[15:0]};
    assign m_ready = m_req;
    assign m_err   = m_req && err_on && (m_addr == err_addr);

    dma_chan_engine u_dma_chan_engine (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .periph_req(periph_req), .m_req(m_req), .m_we(m_we), .m_addr(m_addr),
        .m_wdata(m_wdata), .m_rdata(m_rdata), .m_ready(m_ready), .m_err(m_err),
        .ctrl_o(ctrl_o), .done_o(done_o), .err_o(err_o), .irq(irq)
    );

    function automatic logic [31:0] mem_val(input logic [31:0] a);
        return {~a[15:0], a[15:0]};
    endfunction

    function automatic logic [31:0] mk(input logic en, input logic srst, input logic [1:0] mode,
                                       input logic [1:0] sdir, input logic [1:0] ddir,
                                       input logic [1:0] wid, input logic trig);
        return {21'd0, trig, wid, ddir, sdir, mode, srst, en};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
        @(posedge clk); #2;
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #2;
        reg_wr = 1'b0;
    endtask

    task automatic push_exp(input logic [31:0] a, input logic [31:0] d);
        exp_addr.push_back(a);
        exp_data.push_back(d);
    endtask

    task automatic wait_flag();
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (done_o || err_o) break;
        end
    endtask

    task automatic setup(input logic [31:0] s, input logic [31:0] d, input logic [31:0] n);
        reg_write(3'd1, s);
        reg_write(3'd2, d);
        reg_write(3'd3, n);
    endtask

    // monitor: pops the scoreboard on every accepted write beat
    always @(negedge clk) begin
        if (m_req) req_cycles++;
        if (m_req && m_we && m_ready && !m_err) begin
            checks++;
            if (exp_addr.size() == 0) begin
                errors++;
                $display("FAIL R7: actual=unexpected write %h@%h expected=none", m_wdata, m_addr);
            end else begin
                logic [31:0] ea, ed;
                ea = exp_addr.pop_front();
                ed = exp_data.pop_front();
                if (m_addr !== ea || m_wdata !== ed) begin
                    errors++;
                    $display("FAIL R5/R6/R7 write beat: actual=%h@%h expected=%h@%h",
                             m_wdata, m_addr, ed, ea);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int r0;
        logic [10:0] saved;
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        @(negedge clk);
        chk("R1 reset ctrl", {21'd0, ctrl_o}, 32'd0);
        chk("R10 reset irq", {31'd0, irq}, 32'd0);
        chk("R1 reset m_req", {31'd0, m_req}, 32'd0);

        // R4 R5 R7: memory to memory, both addresses incrementing by 4
        setup(32'h100, 32'h200, 3);
        for (int i = 0; i < 3; i++) push_exp(32'h200 + 4*i, mem_val(32'h100 + 4*i));
        reg_write(3'd0, mk(1, 0, 2'b00, 2'b00, 2'b00, 2'b01, 1));
        wait_flag();
        chk("R7 done set", {31'd0, done_o}, 1);
        chk("R7 trigger self-clear", {31'd0, ctrl_o[10]}, 0);
        chk("R10 irq on done", {31'd0, irq}, 1);
        chk("R4 all units moved", exp_addr.size(), 0);

        // R10 write-one-to-clear
        reg_write(3'd4, 32'h1);
        @(negedge clk);
        chk("R10 done cleared", {31'd0, done_o}, 0);
        chk("R10 irq low", {31'd0, irq}, 0);

        // R8 R6 R5: peripheral to memory, 8 bit, source fixed
        setup(32'h40, 32'h300, 3);
        for (int i = 0; i < 3; i++) push_exp(32'h300 + i, mem_val(32'h40) & 32'hFF);
        r0 = req_cycles;
        reg_write(3'd0, mk(1, 0, 2'b01, 2'b10, 2'b00, 2'b01, 1));
        repeat (10) @(negedge clk);
        chk("R8 no read without periph_req", req_cycles - r0, 0);
        periph_req = 1'b1;
        wait_flag();
        periph_req = 1'b0;
        chk("R6 byte units moved", exp_addr.size(), 0);
        reg_write(3'd4, 32'h1);

        // R6 R5: memory to peripheral, 16 bit, destination fixed
        setup(32'h500, 32'h80, 3);
        for (int i = 0; i < 3; i++) push_exp(32'h80, mem_val(32'h500 + 2*i) & 32'hFFFF);
        periph_req = 1'b1;
        reg_write(3'd0, mk(1, 0, 2'b10, 2'b00, 2'b10, 2'b10, 1));
        wait_flag();
        periph_req = 1'b0;
        chk("R6 half-word units moved", exp_addr.size(), 0);
        reg_write(3'd4, 32'h1);

        // R7 count zero completes with no beat
        setup(32'h100, 32'h200, 0);
        r0 = req_cycles;
        reg_write(3'd0, mk(1, 0, 2'b00, 2'b00, 2'b00, 2'b00, 1));
        wait_flag();
        chk("R7 zero count done", {31'd0, done_o}, 1);
        chk("R7 zero count no beat", req_cycles - r0, 0);
        reg_write(3'd4, 32'h1);

        // R1 enable gating
        setup(32'h140, 32'h240, 2);
        r0 = req_cycles;
        periph_req = 1'b1;
        reg_write(3'd0, mk(0, 0, 2'b00, 2'b00, 2'b00, 2'b00, 1));
        repeat (10) @(negedge clk);
        chk("R1 disabled no request", req_cycles - r0, 0);
        chk("R1 trigger held pending", {31'd0, ctrl_o[10]}, 1);
        periph_req = 1'b0;
        for (int i = 0; i < 2; i++) push_exp(32'h240 + 4*i, mem_val(32'h140 + 4*i));
        reg_write(3'd0, mk(1, 0, 2'b00, 2'b00, 2'b00, 2'b00, 1));
        wait_flag();
        chk("R1 runs after enable", exp_addr.size(), 0);
        reg_write(3'd4, 32'h1);

        // R9 bus error on the second read, then R2 R3 soft reset
        setup(32'h600, 32'h680, 3);
        err_on = 1'b1; err_addr = 32'h604;
        push_exp(32'h680, mem_val(32'h600));
        reg_write(3'd0, mk(1, 0, 2'b00, 2'b00, 2'b00, 2'b00, 1));
        wait_flag();
        err_on = 1'b0;
        chk("R9 error flag", {31'd0, err_o}, 1);
        chk("R9 trigger cleared", {31'd0, ctrl_o[10]}, 0);
        chk("R9 irq on error", {31'd0, irq}, 1);
        r0 = req_cycles;
        reg_write(3'd0, mk(1, 0, 2'b00, 2'b00, 2'b00, 2'b00, 1));
        repeat (10) @(negedge clk);
        chk("R9 retrigger ignored while halted", req_cycles - r0, 0);
        saved = ctrl_o;
        reg_write(3'd0, mk(0, 1, 2'b00, 2'b00, 2'b00, 2'b00, 0));
        @(negedge clk);
        chk("R3 srst visible", {31'd0, ctrl_o[1]}, 1);
        chk("R3 srst clears enable and trigger", {30'd0, ctrl_o[10], ctrl_o[0]}, 0);
        chk("R2 setup kept", {23'd0, ctrl_o[9:2]}, {23'd0, saved[9:2]});
        repeat (5) @(negedge clk);
        chk("R3 srst self-clears", {31'd0, ctrl_o[1]}, 0);
        reg_write(3'd4, 32'h2);
        for (int i = 0; i < 3; i++) push_exp(32'h680 + 4*i, mem_val(32'h600 + 4*i));
        reg_write(3'd0, mk(1, 0, 2'b00, 2'b00, 2'b00, 2'b00, 1));
        wait_flag();
        chk("R2 restart from base", exp_addr.size(), 0);
        chk("R2 restart done", {31'd0, done_o}, 1);
        reg_write(3'd4, 32'h1);

        // R10 collision: clear issued on the edge that sets done
        setup(32'h780, 32'h700, 2);
        for (int i = 0; i < 2; i++) push_exp(32'h700 + 4*i, mem_val(32'h780 + 4*i));
        reg_write(3'd0, mk(1, 0, 2'b00, 2'b00, 2'b00, 2'b00, 1));
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (m_req && m_we && m_addr == 32'h704) break;
        end
        reg_wr = 1'b1; reg_addr = 3'd4; reg_wdata = 32'h1;
        @(posedge clk); #2;
        reg_wr = 1'b0;
        @(negedge clk);
        chk("R10 set wins over clear", {31'd0, done_o}, 1);
        chk("R10 irq kept", {31'd0, irq}, 1);
        chk("R7 trigger cleared at collision", {31'd0, ctrl_o[10]}, 0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule